// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block produces the line sync, frame sync and data-enable window for a 320x240 TFT panel. It counts ticks of the pixel-port clock. A clocks-per-pixel setting of 1, 2 or 3 stretches every horizontal interval by that factor. It suits a panel fed by a 16-bit port (one tick per pixel) or by a narrow 8-bit port that needs two or three ticks per pixel. In the narrow modes, a fixed pipeline correction of a few ticks moves the start of the active window later, to allow for the latency of the external packing logic.

A frame has 244 lines. The first two lines and the last two lines are blanking lines, and the 240 lines in between carry image data. Both syncs are active low and start at the first tick of their period. The block also exports its tick-within-line counter and its line counter, so that a frame fetcher can align its reads to them. Raising `enable` starts both counters together from tick 0 of line 0, using the clocks-per-pixel setting sampled at that moment. Lowering `enable` returns the block to idle at the next clock edge.

Top module: `lcdt_sync_gen`

## Requirements
- R1: While `enable` has been low at the most recent clock edge, and throughout reset, `hsync_n` and `vsync_n` are 1, `de` is 0, and `pix_tick` and `line_idx` are 0.
- R2: `cpp_sel` selects the ticks per pixel: code 0 or 1 gives 1, code 2 gives 2, code 3 gives 3. The value is sampled at the edge where `enable` is first seen high. Later changes to `cpp_sel` are ignored until the block has been idle for at least one edge.
- R3: A line lasts 336×cpp ticks. After the enabling edge, `pix_tick` reads 0 and then rises by one per clock edge up to 336×cpp−1, after which it wraps to 0.
- R4: `line_idx` steps by one each time `pix_tick` wraps. It counts 0 to 243 and then wraps to 0, so a frame lasts 244 line periods.
- R5: `hsync_n` is 0 exactly when `pix_tick` < 2×cpp, on every line.
- R6: `vsync_n` is 0 exactly when `line_idx` is 0 and `pix_tick` < 2×cpp.
- R7: On an image line, `de` first rises at `pix_tick` = 7×cpp + corr, where corr is 0, 3 or 5 ticks for cpp 1, 2 or 3.
- R8: `de` is high for exactly 320×cpp consecutive ticks on each of lines 2 to 241, and stays low on lines 0, 1, 242 and 243.
- R9: When `enable` is dropped partway through a frame, the block is idle (as in R1) after the next edge. Raising `enable` again restarts from tick 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the timing when high; idle and clear when low |
| cpp_sel | input | 2 | Clocks-per-pixel code (0/1, 2, 3) |
| hsync_n | output | 1 | Line sync, active low |
| vsync_n | output | 1 | Frame sync, active low |
| de | output | 1 | Data-enable window for valid pixels |
| pix_tick | output | 12 | Tick index within the current line |
| line_idx | output | 9 | Line index within the current frame |

## Verification
The bench compares every output cycle by cycle against a model computed from the requirements. It covers a complete frame and its wrap at 1 tick per pixel, and the first lines at 2 and 3 ticks per pixel. A wrong pipeline correction would move the first `de` tick and fail in one mode only. An off-by-one window would give 319 or 321 pixels per line, and a blanking split of 3 and 1 would light `de` on line 1 or on line 242. Other cases checked are a change of `cpp_sel` while running, which must not alter the line length, and code 0, which must act as 1. A disable in the middle of a line must return the block to idle at once and restart it cleanly at tick 0, not resume where it stopped.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
   localparam int TICK_W = 12;
   localparam int LINE_W = 9;
   localparam int MAX_CPP = 3;

   typedef logic [TICK_W-1:0] tick_t;
   typedef logic [LINE_W-1:0] line_t;

   // Horizontal thresholds, all in ticks, for the latched clocks-per-pixel.
   typedef struct packed {
      tick_t last;      // final tick of a line
      tick_t hs_end;    // first tick after the line sync pulse
      tick_t de_start;  // first valid pixel tick
      tick_t de_end;    // first tick after the valid window
   } hwin_t;

   function automatic logic [1:0] norm_cpp(input logic [1:0] sel);
      return (sel == 2'd0) ? 2'd1 : sel;
   endfunction
endpackage

// File: rtl/lcdt_ctl.sv
module lcdt_ctl
   import lcdt_pkg::*;
#(
   parameter int H_TOTAL  = 336,
   parameter int H_ACTIVE = 320,
   parameter int H_SYNC   = 2,
   parameter int H_LEAD   = 7,
   parameter int CORR1    = 0,
   parameter int CORR2    = 3,
   parameter int CORR3    = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic [1:0] cpp_sel,
   output logic       run,
   output logic [1:0] cpp,
   output hwin_t      win
);
   hwin_t tbl [4];
   logic [1:0] sel_n;

   generate
      for (genvar m = 0; m < 4; m++) begin : g_mode
         localparam int CPP  = (m == 0) ? 1 : m;
         localparam int CORR = (CPP == 1) ? CORR1 : (CPP == 2) ? CORR2 : CORR3;
         localparam int DE_S = H_LEAD * CPP + CORR;
         localparam int DE_E = DE_S + H_ACTIVE * CPP;
         if (DE_E > H_TOTAL * CPP) begin : g_bad_window
            $error("active window overruns the line in mode %0d", CPP);
         end
         assign tbl[m] = '{last:     tick_t'(H_TOTAL * CPP - 1),
                           hs_end:   tick_t'(H_SYNC * CPP),
                           de_start: tick_t'(DE_S),
                           de_end:   tick_t'(DE_E)};
      end
   endgenerate

   assign sel_n = norm_cpp(cpp_sel);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run <= 1'b0;
         cpp <= 2'd1;
         win <= tbl[1];
      end else begin
         run <= enable;
         if (enable && !run) begin
            cpp <= sel_n;
            win <= tbl[sel_n];
         end
      end
   end
endmodule

// File: rtl/lcdt_hcount.sv
module lcdt_hcount
   import lcdt_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  enable,
   input  logic  run,
   input  tick_t last,
   output tick_t tick,
   output logic  wrap
);
   assign wrap = run && (tick == last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick <= '0;
      end else if (!enable || !run) begin
         tick <= '0;
      end else if (wrap) begin
         tick <= '0;
      end else begin
         tick <= tick + tick_t'(1);
      end
   end
endmodule

// File: rtl/lcdt_vcount.sv
module lcdt_vcount
   import lcdt_pkg::*;
#(
   parameter int V_TOTAL = 244
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  enable,
   input  logic  run,
   input  logic  wrap,
   output line_t line
);
   localparam line_t LAST = line_t'(V_TOTAL - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line <= '0;
      end else if (!enable || !run) begin
         line <= '0;
      end else if (wrap) begin
         line <= (line == LAST) ? '0 : line + line_t'(1);
      end
   end
endmodule

// File: rtl/lcdt_decode.sv
module lcdt_decode
   import lcdt_pkg::*;
#(
   parameter int V_TOP     = 2,
   parameter int V_VISIBLE = 240,
   parameter int V_SYNC    = 2
) (
   input  logic       run,
   input  logic [1:0] cpp,
   input  hwin_t      win,
   input  tick_t      tick,
   input  line_t      line,
   output logic       hsync_n,
   output logic       vsync_n,
   output logic       de
);
   localparam line_t FIRST_IMG = line_t'(V_TOP);
   localparam line_t END_IMG   = line_t'(V_TOP + V_VISIBLE);

   tick_t vs_end;
   logic  img_line;

   assign vs_end   = tick_t'(V_SYNC * int'(cpp));
   assign img_line = (line >= FIRST_IMG) && (line < END_IMG);

   always_comb begin
      hsync_n = !(run && (tick < win.hs_end));
      vsync_n = !(run && (line == '0) && (tick < vs_end));
      de      = run && img_line && (tick >= win.de_start) && (tick < win.de_end);
   end
endmodule

// File: rtl/lcdt_sync_gen.sv
module lcdt_sync_gen
   import lcdt_pkg::*;
#(
   parameter int H_TOTAL   = 336,
   parameter int H_ACTIVE  = 320,
   parameter int H_SYNC    = 2,
   parameter int H_LEAD    = 7,
   parameter int V_VISIBLE = 240,
   parameter int V_BLANK   = 4,
   parameter int V_SYNC    = 2,
   parameter int CORR1     = 0,
   parameter int CORR2     = 3,
   parameter int CORR3     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [1:0]        cpp_sel,
   output logic              hsync_n,
   output logic              vsync_n,
   output logic              de,
   output logic [TICK_W-1:0] pix_tick,
   output logic [LINE_W-1:0] line_idx
);
   localparam int V_TOTAL = V_VISIBLE + V_BLANK;
   localparam int V_TOP   = V_BLANK / 2;

   generate
      if (H_TOTAL * MAX_CPP > (1 << TICK_W)) begin : g_bad_tick_w
         $error("tick counter too narrow for the line length");
      end
      if (V_TOTAL > (1 << LINE_W)) begin : g_bad_line_w
         $error("line counter too narrow for the frame height");
      end
      if (V_SYNC > H_TOTAL) begin : g_bad_vsync
         $error("frame sync wider than a line");
      end
   endgenerate

   logic       run;
   logic [1:0] cpp_q;
   hwin_t      win;
   logic       wrap;

   lcdt_ctl #(
      .H_TOTAL(H_TOTAL), .H_ACTIVE(H_ACTIVE), .H_SYNC(H_SYNC), .H_LEAD(H_LEAD),
      .CORR1(CORR1), .CORR2(CORR2), .CORR3(CORR3)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cpp_sel(cpp_sel),
      .run(run), .cpp(cpp_q), .win(win)
   );

   lcdt_hcount u_hcnt (
      .clk(clk), .rst_n(rst_n), .enable(enable), .run(run),
      .last(win.last), .tick(pix_tick), .wrap(wrap)
   );

   lcdt_vcount #(.V_TOTAL(V_TOTAL)) u_vcnt (
      .clk(clk), .rst_n(rst_n), .enable(enable), .run(run),
      .wrap(wrap), .line(line_idx)
   );

   lcdt_decode #(.V_TOP(V_TOP), .V_VISIBLE(V_VISIBLE), .V_SYNC(V_SYNC)) u_dec (
      .run(run), .cpp(cpp_q), .win(win), .tick(pix_tick), .line(line_idx),
      .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de)
   );
endmodule

// File: rtl/lcdt_sync_chk.sv
module lcdt_sync_chk
   import lcdt_pkg::*;
#(
   parameter int H_TOTAL   = 336,
   parameter int H_SYNC    = 2,
   parameter int H_LEAD    = 7,
   parameter int V_VISIBLE = 240,
   parameter int V_BLANK   = 4,
   parameter int CORR1     = 0,
   parameter int CORR2     = 3,
   parameter int CORR3     = 5
) (
   input logic       clk,
   input logic       rst_n,
   input logic       enable,
   input logic       run,
   input logic [1:0] cpp,
   input logic       hsync_n,
   input logic       vsync_n,
   input logic       de,
   input tick_t      pix_tick,
   input line_t      line_idx
);
   localparam int V_TOTAL = V_VISIBLE + V_BLANK;
   localparam int V_TOP   = V_BLANK / 2;

   int c, lead;
   assign c    = int'(cpp);
   assign lead = H_LEAD * c + ((c == 1) ? CORR1 : (c == 2) ? CORR2 : CORR3);

   assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(enable) |-> (hsync_n && vsync_n && !de && pix_tick == '0 && line_idx == '0));

   assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> $stable(cpp));

   assert_line_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && enable && int'(pix_tick) == H_TOTAL * c - 1) |=> (pix_tick == '0));

   assert_line_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (line_idx != $past(line_idx)) |-> (pix_tick == '0 && int'(line_idx) < V_TOTAL));

   assert_hsync_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !hsync_n |-> (run && int'(pix_tick) < H_SYNC * c));

   assert_vsync_span_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !vsync_n |-> (!hsync_n && line_idx == '0));

   assert_de_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(de) |-> (int'(pix_tick) == lead));

   assert_de_lines_R8: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (int'(line_idx) >= V_TOP && int'(line_idx) < V_TOP + V_VISIBLE));
endmodule

bind lcdt_sync_gen lcdt_sync_chk #(
   .H_TOTAL(H_TOTAL), .H_SYNC(H_SYNC), .H_LEAD(H_LEAD),
   .V_VISIBLE(V_VISIBLE), .V_BLANK(V_BLANK),
   .CORR1(CORR1), .CORR2(CORR2), .CORR3(CORR3)
) u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .run(run), .cpp(cpp_q),
   .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
   .pix_tick(pix_tick), .line_idx(line_idx)
);

// File: tb/lcdt_sync_gen_test.sv
`timescale 1ns/1ps
module lcdt_sync_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [1:0]  cpp_sel = 2'd1;
   logic        hsync_n, vsync_n, de;
   logic [11:0] pix_tick;
   logic [8:0]  line_idx;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lcdt_sync_gen uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cpp_sel(cpp_sel),
      .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
      .pix_tick(pix_tick), .line_idx(line_idx)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int corr_of(input int cpp);
      return (cpp == 1) ? 0 : (cpp == 2) ? 3 : 5;
   endfunction

   task automatic check_idle(input string req, input string what);
      check(hsync_n === 1'b1, req, {what, " hsync_n"}, int'(hsync_n), 1);
      check(vsync_n === 1'b1, req, {what, " vsync_n"}, int'(vsync_n), 1);
      check(de === 1'b0, req, {what, " de"}, int'(de), 0);
      check(pix_tick === 12'd0, req, {what, " pix_tick"}, int'(pix_tick), 0);
      check(line_idx === 9'd0, req, {what, " line_idx"}, int'(line_idx), 0);
   endtask

   // Drop enable for one edge, then run `cycles` ticks with model cpp `mcpp`.
   // At tick index chg_at, cpp_sel is rewritten to chg_val (R2).
   task automatic run_span(input logic [1:0] sel, input int mcpp, input int cycles,
                           input int chg_at, input logic [1:0] chg_val,
                           input string tag, output int de_per_line [0:243]);
      int errc [5];
      int fa [5];
      int fe [5];
      int lt, st;
      for (int i = 0; i < 5; i++) begin errc[i] = 0; fa[i] = 0; fe[i] = 0; end
      for (int i = 0; i < 244; i++) de_per_line[i] = 0;
      lt = 336 * mcpp;
      st = 7 * mcpp + corr_of(mcpp);
      @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      cpp_sel = sel;
      enable = 1'b1;
      for (int k = 1; k <= cycles; k++) begin
         int t, eh, ev, ehs, evs, ede;
         int act [5];
         int exv [5];
         @(negedge clk);
         t = k - 1;
         eh = t % lt;
         ev = (t / lt) % 244;
         ehs = (eh < 2 * mcpp) ? 0 : 1;
         evs = (ev == 0 && eh < 2 * mcpp) ? 0 : 1;
         ede = (ev >= 2 && ev < 242 && eh >= st && eh < st + 320 * mcpp) ? 1 : 0;
         act[0] = int'(pix_tick); exv[0] = eh;
         act[1] = int'(line_idx); exv[1] = ev;
         act[2] = int'(hsync_n);  exv[2] = ehs;
         act[3] = int'(vsync_n);  exv[3] = evs;
         act[4] = int'(de);       exv[4] = ede;
         for (int i = 0; i < 5; i++) begin
            if (act[i] != exv[i]) begin
               if (errc[i] == 0) begin fa[i] = act[i]; fe[i] = exv[i]; end
               errc[i]++;
            end
         end
         if (t < lt * 244 && de === 1'b1) de_per_line[ev]++;
         if (k == chg_at) cpp_sel = chg_val;
      end
      check(errc[0] == 0, "R3", {tag, " pix_tick sequence"}, fa[0], fe[0]);
      check(errc[1] == 0, "R4", {tag, " line_idx sequence"}, fa[1], fe[1]);
      check(errc[2] == 0, "R5", {tag, " hsync_n pattern"}, fa[2], fe[2]);
      check(errc[3] == 0, "R6", {tag, " vsync_n pattern"}, fa[3], fe[3]);
      check(errc[4] == 0, "R7", {tag, " de window position"}, fa[4], fe[4]);
   endtask

   task automatic test_reset();
      repeat (3) @(negedge clk);
      check_idle("R1", "in reset");
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check_idle("R1", "enable low after reset");
   endtask

   task automatic test_full_frame_cpp1();
      int dl [0:243];
      run_span(2'd1, 1, 336 * 244 + 336 * 3, 0, 2'd1, "cpp1 frame", dl);
      check(dl[2] == 320, "R8", "cpp1 de ticks line 2", dl[2], 320);
      check(dl[241] == 320, "R8", "cpp1 de ticks line 241", dl[241], 320);
      check(dl[0] + dl[1] == 0, "R8", "cpp1 de ticks top blanking", dl[0] + dl[1], 0);
      check(dl[242] + dl[243] == 0, "R8", "cpp1 de ticks bottom blanking",
            dl[242] + dl[243], 0);
   endtask

   task automatic test_cpp2();
      int dl [0:243];
      run_span(2'd2, 2, 336 * 2 * 4, 0, 2'd2, "cpp2", dl);
      check(dl[2] == 640, "R8", "cpp2 de ticks line 2", dl[2], 640);
      check(dl[1] == 0, "R8", "cpp2 de ticks line 1", dl[1], 0);
   endtask

   task automatic test_cpp3();
      int dl [0:243];
      run_span(2'd3, 3, 336 * 3 * 4, 0, 2'd3, "cpp3", dl);
      check(dl[3] == 960, "R8", "cpp3 de ticks line 3", dl[3], 960);
   endtask

   task automatic test_code_zero();
      int dl [0:243];
      run_span(2'd0, 1, 336 * 3, 0, 2'd0, "code0 as cpp1 R2", dl);
      check(dl[2] == 320, "R2", "code0 de ticks line 2", dl[2], 320);
   endtask

   task automatic test_mode_change_ignored();
      int dl [0:243];
      run_span(2'd1, 1, 336 * 3, 100, 2'd3, "midrun cpp_sel change R2", dl);
      check(dl[2] == 320, "R2", "line 2 kept cpp1 width", dl[2], 320);
   endtask

   task automatic test_disable_midline();
      int dl [0:243];
      run_span(2'd2, 2, 1500, 0, 2'd2, "cpp2 before drop", dl);
      @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      check_idle("R9", "one edge after drop");
      repeat (5) @(negedge clk);
      check_idle("R9", "held low");
      run_span(2'd3, 3, 336 * 3 * 3, 0, 2'd3, "restart after drop R9", dl);
      check(dl[2] == 960, "R9", "restart cpp3 de ticks line 2", dl[2], 960);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      test_reset();
      test_full_frame_cpp1();
      test_cpp2();
      test_cpp3();
      test_code_zero();
      test_mode_change_ignored();
      test_disable_midline();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule